// File: doc/BRIEF.md
# Single-Source Interrupt Register Group

This block holds the pending flag and the mask flag of one interrupt source behind a small word-wide register bus. A hardware event pulse sets the pending flag. Software clears it by writing a one to it. Software never writes the mask flag directly. It arms the source through an enable port and disarms it through a disable port, and each of those writes acts on the mask as a bitwise clear or set. A level interrupt output is high while the flag is pending and not masked.

The bus carries an address, a write strobe with write data, and a read strobe with read data. Every access is a full 32-bit word. There are no byte lanes. Read data is combinational and is valid in the cycle the read strobe is high. Writes take effect at the clock edge that samples the strobe. The interrupt output is decoded combinationally from the two flag registers, so it follows a register change in the same cycle that change becomes visible. The block has no data stream, so every pin is a plain control or status pin.

Register offsets are: 0x00 pending, 0x04 mask, 0x08 enable port, 0x0C disable port. Only bit 0 is implemented in each register.

Top module: `evt_irq_regs`

## Requirements
- R1: While reset is asserted and right after it is released, the pending flag is 0, the mask flag is 1 and irq_out is 0.
- R2: An event_in pulse sampled at a clock edge sets the pending flag from the next cycle. The flag stays set until it is cleared.
- R3: A write to offset 0x00 with data bit 0 equal to 1 clears the pending flag. A write there with bit 0 equal to 0 leaves it unchanged. The other data bits are ignored.
- R4: When event_in and a clearing write to 0x00 fall in the same cycle, the pending flag stays set.
- R5: A write to offset 0x04 has no effect on the mask flag, whatever the data.
- R6: A write to offset 0x08 with data bit 0 equal to 1 clears the mask flag. With bit 0 equal to 0 the mask is unchanged.
- R7: A write to offset 0x0C with data bit 0 equal to 1 sets the mask flag. With bit 0 equal to 0 the mask is unchanged.
- R8: irq_out equals pending AND NOT mask in every cycle. It follows each register change in the cycle the change appears.
- R9: With rd_en high, offset 0x00 returns the pending flag in bit 0 and offset 0x04 returns the mask flag in bit 0. Offsets 0x08 and 0x0C return 0, and bits 31:1 always read 0. With rd_en low, rd_data is 0.
- R10: An address that is not a multiple of four or lies above 0x0C is unmapped. Reads of it return 0, and writes to it change neither flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W (4) | Byte offset of the access |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DATA_W (32) | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | DATA_W (32) | Read data, combinational |
| event_in | input | 1 | Hardware event that sets the pending flag |
| irq_out | output | 1 | Level interrupt request |

## Verification
A corrupted pending or mask flag appears on irq_out in the same cycle it is registered. Reading offset 0x00 or 0x04 in any later cycle also exposes it in bit 0. A decode fault appears at the first write to a neighbouring or unaligned offset: the next readback of the wrong flag shows the change, and irq_out shows it if the pair no longer pends unmasked. A lost event-over-clear priority shows as pending reading 0 one cycle after the colliding write.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned OFS_STAT = 'h0;
  localparam int unsigned OFS_MASK = 'h4;
  localparam int unsigned OFS_EN   = 'h8;
  localparam int unsigned OFS_DIS  = 'hC;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_STAT,
    SEL_MASK,
    SEL_EN,
    SEL_DIS
  } reg_sel_e;
endpackage

// File: rtl/evt_irq_addr_dec.sv
module evt_irq_addr_dec
  import evt_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output reg_sel_e          sel
);
  localparam int unsigned AW = (ADDR_W < 32) ? 32 : ADDR_W;
  logic [AW-1:0] ofs;

  always_comb begin
    ofs = '0;
    ofs[ADDR_W-1:0] = addr;
    if      (ofs == AW'(OFS_STAT)) sel = SEL_STAT;
    else if (ofs == AW'(OFS_MASK)) sel = SEL_MASK;
    else if (ofs == AW'(OFS_EN))   sel = SEL_EN;
    else if (ofs == AW'(OFS_DIS))  sel = SEL_DIS;
    else                           sel = SEL_NONE;
  end
endmodule

// File: rtl/evt_irq_stat_bit.sv
module evt_irq_stat_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic clr,
  output logic stat_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    stat_q <= 1'b0;
    else if (evt)  stat_q <= 1'b1;
    else if (clr)  stat_q <= 1'b0;
  end

  // R2
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> stat_q);
  // R3
  clr_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !evt) |=> !stat_q);
  // R3
  stat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !evt) |=> $stable(stat_q));
endmodule

// File: rtl/evt_irq_mask_bit.sv
module evt_irq_mask_bit (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic disarm,
  output logic mask_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      mask_q <= 1'b1;
    else if (disarm) mask_q <= 1'b1;
    else if (arm)    mask_q <= 1'b0;
  end

  // R6
  arm_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !disarm) |=> !mask_q);
  // R7
  disarm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disarm |=> mask_q);
  // R5
  mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!arm && !disarm) |=> $stable(mask_q));
endmodule

// File: rtl/evt_irq_rd_mux.sv
module evt_irq_rd_mux
  import evt_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              rd_en,
  input  reg_sel_e          sel,
  input  logic              stat_q,
  input  logic              mask_q,
  output logic [DATA_W-1:0] rd_data
);
  always_comb begin
    rd_data = '0;
    if (rd_en) begin
      unique case (sel)
        SEL_STAT: rd_data[0] = stat_q;
        SEL_MASK: rd_data[0] = mask_q;
        default:  rd_data    = '0;
      endcase
    end
  end
endmodule

// File: rtl/evt_irq_regs.sv
module evt_irq_regs
  import evt_irq_pkg::*;
#(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic              event_in,
  output logic              irq_out
);
  reg_sel_e sel;
  logic     stat_q, mask_q;
  logic     w_clr, w_arm, w_disarm;
  logic     wdata_unused;

  assign wdata_unused = ^wr_data[DATA_W-1:1];

  evt_irq_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  assign w_clr    = wr_en && (sel == SEL_STAT) && wr_data[0];
  assign w_arm    = wr_en && (sel == SEL_EN)   && wr_data[0];
  assign w_disarm = wr_en && (sel == SEL_DIS)  && wr_data[0];

  evt_irq_stat_bit u_stat (
    .clk    (clk),
    .rst_n  (rst_n),
    .evt    (event_in),
    .clr    (w_clr),
    .stat_q (stat_q)
  );

  evt_irq_mask_bit u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (w_arm),
    .disarm (w_disarm),
    .mask_q (mask_q)
  );

  evt_irq_rd_mux #(.DATA_W(DATA_W)) u_rd (
    .rd_en   (rd_en),
    .sel     (sel),
    .stat_q  (stat_q),
    .mask_q  (mask_q),
    .rd_data (rd_data)
  );

  assign irq_out = stat_q & ~mask_q;

  // R8
  irq_masked_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq_out);
  // R9
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-1:1] == '0);
  // R10
  unmapped_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_NONE && !event_in) |=> ($stable(stat_q) && $stable(mask_q)));
  // R4
  evt_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (event_in && w_clr) |=> stat_q);
endmodule

// File: tb/test_evt_irq_regs.sv
`timescale 1ns/100ps
module test_evt_irq_regs;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          wr_en = 1'b0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [DW-1:0] rd_data;
  logic          event_in = 1'b0;
  logic          irq_out;

  always #2.5 clk = ~clk;

  evt_irq_regs #(.ADDR_W(AW), .DATA_W(DW)) i_evt_irq_regs (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .event_in(event_in), .irq_out(irq_out)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit ms = 1'b0;
  bit mm = 1'b1;
  logic [DW:0] exp_q[$];
  string       tag_q[$];

  task automatic sample(input logic [AW-1:0] a, input logic re, input string tag);
    logic [DW-1:0] d;
    @(negedge clk);
    addr = a; rd_en = re; wr_en = 1'b0;
    d = '0;
    if (re && a == 4'h0) d[0] = ms;
    if (re && a == 4'h4) d[0] = mm;
    exp_q.push_back({ms & ~mm, d});
    tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic ev);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1; event_in = ev;
    @(negedge clk);
    wr_en = 1'b0; event_in = 1'b0;
    if (ev) ms = 1'b1;
    else if (a == 4'h0 && d[0]) ms = 1'b0;
    if (a == 4'h8 && d[0]) mm = 1'b0;
    if (a == 4'hC && d[0]) mm = 1'b1;
  endtask

  task automatic pulse_evt();
    @(negedge clk);
    event_in = 1'b1;
    @(negedge clk);
    event_in = 1'b0;
    ms = 1'b1;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [DW:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_cmp++;
        if (rd_data !== e[DW-1:0] || irq_out !== e[DW]) begin
          n_bad++;
          $display("FAIL %s: rd_data=%h irq=%b expected rd_data=%h irq=%b",
                   t, rd_data, irq_out, e[DW-1:0], e[DW]);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  initial begin : driver
    sample(4'h0, 1'b1, "R1 pending in reset");
    sample(4'h4, 1'b1, "R1 mask in reset");
    @(negedge clk); rst_n = 1'b1;
    sample(4'h4, 1'b1, "R1 mask after reset");
    wr(4'h4, 32'h0, 1'b0);
    sample(4'h4, 1'b1, "R5 direct mask write of 0");
    pulse_evt();
    sample(4'h0, 1'b1, "R2 event sets pending while masked R8");
    wr(4'h8, 32'hFFFF_FFFE, 1'b0);
    sample(4'h4, 1'b1, "R6 enable write with bit0 zero");
    wr(4'h8, 32'h1, 1'b0);
    sample(4'h4, 1'b1, "R6 enable clears mask R8 irq high");
    wr(4'h4, 32'hFFFF_FFFF, 1'b0);
    sample(4'h4, 1'b1, "R5 direct mask write of ones");
    sample(4'h8, 1'b1, "R9 enable port reads zero");
    sample(4'hC, 1'b1, "R9 disable port reads zero");
    sample(4'h0, 1'b0, "R9 rd_en low gives zero");
    wr(4'h0, 32'hFFFF_FFFE, 1'b0);
    sample(4'h0, 1'b1, "R3 write 0 to bit0 keeps pending");
    wr(4'h1, 32'h1, 1'b0);
    wr(4'hD, 32'h1, 1'b0);
    sample(4'h0, 1'b1, "R10 unaligned write ignored");
    sample(4'h4, 1'b1, "R10 unaligned disable ignored");
    sample(4'h5, 1'b1, "R10 unaligned read zero");
    wr(4'h0, 32'h1, 1'b1);
    sample(4'h0, 1'b1, "R4 event beats clear");
    wr(4'h0, 32'h1, 1'b0);
    sample(4'h0, 1'b1, "R3 clear pending R8 irq low");
    pulse_evt();
    sample(4'h0, 1'b1, "R8 irq high on new event");
    wr(4'hC, 32'h0, 1'b0);
    sample(4'h4, 1'b1, "R7 disable write with bit0 zero");
    wr(4'hC, 32'h1, 1'b0);
    sample(4'h4, 1'b1, "R7 disable sets mask R8 irq low");
    sample(4'h0, 1'b1, "R2 pending held while masked");
    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL scoreboard: %0d items left expected 0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule